// File: doc/BRIEF.md
# Burst-of-Two Dual-Port DDR SRAM Core

This block models a small synchronous static memory with an independent read port and write port. Both ports move data on both edges of the input clock, and every access moves a fixed pair of words. Read and write commands are sampled on the rising edge of `clk_k`. The write address and the second write beat follow on the falling edge of the same clock, which stands for the complementary input clock.

The first write beat arrives half a cycle before its address, so it waits in a one-entry buffer until the falling edge. On that edge the pair is committed to the array. A read issued on the same rising edge is looked up on that falling edge. A per-lane bypass lets the read see the bytes that are being committed in the same instant.

Read data leaves through a double-data-rate output stage. The first word appears on the falling edge 1.5 cycles after the command, and the second word appears on the next rising edge. Output timing is taken from the input clock, which is the mode where separate output clocks are held high. Two echo clocks run alongside the data so that a receiver can capture each beat.

Top module: `qdr_b2_sram`

## Requirements
- R1: A burst address names a pair of words: word `{addr,0}` is beat one and word `{addr,1}` is beat two, and every access transfers both.
- R2: On a rising edge of `clk_k` the block samples `rd_n`, `rd_addr`, `wr_n`, the first write beat on `wdata` and its lane mask on `bw_n`.
- R3: On the falling edge that follows a write command, the block samples `wr_addr`, the second write beat on `wdata` and its lane mask on `bw_n`, and commits both beats.
- R4: A read sampled at rising edge t shows beat one on `rdata` from the falling edge at t+1.5 cycles, and beat two from the rising edge at t+2 cycles. Reads on consecutive cycles give an unbroken stream.
- R5: Lane l covers bits [9l+8:9l] of a word (4 lanes at 36 bits). A low `bw_n[l]` writes that lane of the current beat and a high bit leaves it unchanged, independently for each beat.
- R6: With `rd_n` high at a rising edge no read starts and `rvalid` stays low in that slot. With `wr_n` high the array is unchanged, whatever is on `wr_addr`, `wdata` and `bw_n`.
- R7: A read sampled on the same rising edge as a write to the same address returns the newly written lanes merged with the old ones. A write issued on a later edge does not affect an earlier read.
- R8: `rvalid` is high exactly during the two half-cycle beat windows of each read, and `rdata` is zero whenever `rvalid` is low.
- R9: `echo_p` follows `clk_k` and `echo_n` is its complement.
- R10: Synchronous active-high `rst` drops every pending command and read in flight, and holds `rvalid` low and `rdata` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock. The rising edge takes commands and the falling edge takes the write address |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Read command, active low |
| wr_n | input | 1 | Write command, active low |
| rd_addr | input | ADDR_W | Read burst address |
| wr_addr | input | ADDR_W | Write burst address, sampled on the falling edge |
| wdata | input | DATA_W | Write data: beat one on the rising edge, beat two on the falling edge |
| bw_n | input | DATA_W/9 | Per-lane write enables, active low, one set per beat |
| rdata | output | DATA_W | Read data, double data rate |
| rvalid | output | 1 | High while `rdata` carries a read beat |
| echo_p | output | 1 | Echo clock in phase with the data edges |
| echo_n | output | 1 | Complementary echo clock |

## Verification
A read sampled at rising edge n is due on the outputs in two halves. Beat one appears in the low phase after the falling edge 1.5 cycles later, and beat two appears in the high phase after rising edge n+2. The bench drives each cycle as a fixed sequence: it sets the command before the rising edge, then it samples the high-phase outputs 2 time units after that edge and checks them against the read from two cycles back. It then sets the second write beat, and after the falling edge it checks the low-phase outputs against the read from one cycle back. The expected words come from a reference array in the bench. This array applies each write before it answers the read of the same cycle.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

    // Bits per write-enable lane.
    localparam int LANE_W = 9;

    // Position of a word inside its burst pair (lowest word-address bit).
    typedef enum logic {
        BEAT_FIRST  = 1'b0,
        BEAT_SECOND = 1'b1
    } beat_e;

    function automatic int lane_count(input int data_w);
        return data_w / LANE_W;
    endfunction

endpackage

// File: rtl/qdr_cmd_capture.sv
module qdr_cmd_capture
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int NLANE  = 4
) (
    input  logic              clk_k,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NLANE-1:0]  bw_n,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              wr_pend,
    output logic [DATA_W-1:0] wbuf_d0,
    output logic [NLANE-1:0]  wbuf_be0
);

    // Rising-edge capture; the first write beat waits here for its address.
    always_ff @(posedge clk_k) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            wr_pend   <= 1'b0;
            rd_addr_q <= '0;
            wbuf_d0   <= '0;
            wbuf_be0  <= '0;
        end else begin
            rd_pend   <= ~rd_n;
            wr_pend   <= ~wr_n;
            rd_addr_q <= rd_addr;
            wbuf_d0   <= wdata;
            wbuf_be0  <= ~bw_n;
        end
    end

endmodule

// File: rtl/qdr_burst_array.sv
module qdr_burst_array
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int NLANE  = 4
) (
    input  logic              clk_k,
    input  logic              rst,
    input  logic              wr_pend,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wbuf_d0,
    input  logic [NLANE-1:0]  wbuf_be0,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NLANE-1:0]  bw_n,
    input  logic              rd_pend,
    input  logic [ADDR_W-1:0] rd_addr_q,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_w0,
    output logic [DATA_W-1:0] fetch_w1
);

    localparam int WADDR_W = ADDR_W + 1;
    localparam int DEPTH   = 1 << WADDR_W;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [NLANE-1:0]  be0;
        logic [NLANE-1:0]  be1;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
    } wreq_t;

    logic [DATA_W-1:0]  mem [DEPTH];
    wreq_t              wq;
    logic [WADDR_W-1:0] wa0, wa1, ra0, ra1;
    logic [DATA_W-1:0]  old0, old1, byp0, byp1;
    logic               hit;

    // Write request assembled on the falling edge: buffered beat one plus live beat two.
    always_comb begin
        wq.en   = wr_pend;
        wq.addr = wr_addr;
        wq.be0  = wbuf_be0;
        wq.be1  = ~bw_n;
        wq.d0   = wbuf_d0;
        wq.d1   = wdata;
    end

    assign wa0  = {wq.addr, BEAT_FIRST};
    assign wa1  = {wq.addr, BEAT_SECOND};
    assign ra0  = {rd_addr_q, BEAT_FIRST};
    assign ra1  = {rd_addr_q, BEAT_SECOND};
    assign old0 = mem[ra0];
    assign old1 = mem[ra1];
    assign hit  = wq.en && (wq.addr == rd_addr_q);

    // Per-lane bypass of the write committed on the same edge.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign byp0[l*LANE_W +: LANE_W] = (hit && wq.be0[l]) ?
            wq.d0[l*LANE_W +: LANE_W] : old0[l*LANE_W +: LANE_W];
        assign byp1[l*LANE_W +: LANE_W] = (hit && wq.be1[l]) ?
            wq.d1[l*LANE_W +: LANE_W] : old1[l*LANE_W +: LANE_W];
    end

    always_ff @(negedge clk_k) begin
        if (!rst && wq.en) begin
            for (int l = 0; l < NLANE; l++) begin
                if (wq.be0[l]) mem[wa0][l*LANE_W +: LANE_W] <= wq.d0[l*LANE_W +: LANE_W];
                if (wq.be1[l]) mem[wa1][l*LANE_W +: LANE_W] <= wq.d1[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(negedge clk_k) begin
        if (rst) begin
            fetch_valid <= 1'b0;
            fetch_w0    <= '0;
            fetch_w1    <= '0;
        end else begin
            fetch_valid <= rd_pend;
            fetch_w0    <= rd_pend ? byp0 : '0;
            fetch_w1    <= rd_pend ? byp1 : '0;
        end
    end

endmodule

// File: rtl/qdr_read_pipe.sv
module qdr_read_pipe #(
    parameter int DATA_W = 36
) (
    input  logic              clk_k,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [DATA_W-1:0] fetch_w0,
    input  logic [DATA_W-1:0] fetch_w1,
    output logic              v_fall,
    output logic              v_rise,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              echo_p,
    output logic              echo_n
);

    logic [DATA_W-1:0] q_fall, q_rise, hold_w1;
    logic              hold_v;

    // Beat one leaves on the falling edge, beat two waits half a cycle.
    always_ff @(negedge clk_k) begin
        if (rst) begin
            v_fall  <= 1'b0;
            q_fall  <= '0;
            hold_v  <= 1'b0;
            hold_w1 <= '0;
        end else begin
            v_fall  <= fetch_valid;
            q_fall  <= fetch_valid ? fetch_w0 : '0;
            hold_v  <= fetch_valid;
            hold_w1 <= fetch_valid ? fetch_w1 : '0;
        end
    end

    always_ff @(posedge clk_k) begin
        if (rst) begin
            v_rise <= 1'b0;
            q_rise <= '0;
        end else begin
            v_rise <= hold_v;
            q_rise <= hold_w1;
        end
    end

    // The high phase shows the rising-edge register, the low phase the falling one.
    assign rdata  = clk_k ? q_rise : q_fall;
    assign rvalid = clk_k ? v_rise : v_fall;
    assign echo_p = clk_k;
    assign echo_n = ~clk_k;

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic                        clk_k,
    input  logic                        rst,
    input  logic                        rd_n,
    input  logic                        wr_n,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W/LANE_W-1:0]    bw_n,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rvalid,
    output logic                        echo_p,
    output logic                        echo_n
);

    localparam int NLANE = lane_count(DATA_W);

    logic              rd_pend, wr_pend, fetch_valid, v_fall, v_rise;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] wbuf_d0, fetch_w0, fetch_w1;
    logic [NLANE-1:0]  wbuf_be0;

    qdr_cmd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLANE(NLANE)) u_cap (
        .clk_k(clk_k), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .rd_addr(rd_addr),
        .wdata(wdata), .bw_n(bw_n), .rd_pend(rd_pend), .rd_addr_q(rd_addr_q),
        .wr_pend(wr_pend), .wbuf_d0(wbuf_d0), .wbuf_be0(wbuf_be0)
    );

    qdr_burst_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLANE(NLANE)) u_arr (
        .clk_k(clk_k), .rst(rst), .wr_pend(wr_pend), .wr_addr(wr_addr),
        .wbuf_d0(wbuf_d0), .wbuf_be0(wbuf_be0), .wdata(wdata), .bw_n(bw_n),
        .rd_pend(rd_pend), .rd_addr_q(rd_addr_q), .fetch_valid(fetch_valid),
        .fetch_w0(fetch_w0), .fetch_w1(fetch_w1)
    );

    qdr_read_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk_k(clk_k), .rst(rst), .fetch_valid(fetch_valid), .fetch_w0(fetch_w0),
        .fetch_w1(fetch_w1), .v_fall(v_fall), .v_rise(v_rise), .rdata(rdata),
        .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n)
    );

endmodule

// File: rtl/qdr_b2_sram_checker.sv
module qdr_b2_sram_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk_k,
    input logic              rst,
    input logic              rd_pend,
    input logic              fetch_valid,
    input logic              v_fall,
    input logic              v_rise,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              echo_p,
    input logic              echo_n
);

    // R4: an accepted read is looked up on the next falling edge
    a_r4_fetch_follows_cmd: assert property (@(negedge clk_k) disable iff (rst)
        rd_pend |=> fetch_valid);

    // R4: a looked-up pair produces beat one one cycle later
    a_r4_fall_follows_fetch: assert property (@(negedge clk_k) disable iff (rst)
        fetch_valid |=> v_fall);

    // R4: beat two follows beat one half a cycle later
    a_r4_rise_follows_fall: assert property (@(posedge clk_k) disable iff (rst)
        v_fall |=> v_rise);

    // R8: output is zero outside a beat window
    a_r8_idle_zero: assert property (@(negedge clk_k) disable iff (rst)
        !rvalid |-> (rdata == '0));

    // R9: echo clocks are complementary
    a_r9_echo_complement: assert property (@(posedge clk_k) disable iff (rst)
        echo_p != echo_n);

endmodule

bind qdr_b2_sram qdr_b2_sram_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_k(clk_k), .rst(rst), .rd_pend(rd_pend), .fetch_valid(fetch_valid),
    .v_fall(v_fall), .v_rise(v_rise), .rdata(rdata), .rvalid(rvalid),
    .echo_p(echo_p), .echo_n(echo_n)
);

// File: tb/qdr_b2_sram_bench.sv
module qdr_b2_sram_bench;

    localparam int PERIOD = 10;
    localparam int AW     = 6;
    localparam int DW     = 36;
    localparam int NL     = DW / 9;
    localparam int NADDR  = 1 << AW;
    localparam int MAXCYC = 4096;

    logic          clk_k = 1'b0;
    logic          rst   = 1'b1;
    logic          rd_n  = 1'b1;
    logic          wr_n  = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wdata   = '0;
    logic [NL-1:0] bw_n    = '1;
    logic [DW-1:0] rdata;
    logic          rvalid, echo_p, echo_n;

    qdr_b2_sram #(.ADDR_W(AW), .DATA_W(DW)) u_qdr_b2_sram (
        .clk_k(clk_k), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .rd_addr(rd_addr),
        .wr_addr(wr_addr), .wdata(wdata), .bw_n(bw_n), .rdata(rdata),
        .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n)
    );

    always #(PERIOD/2) clk_k = ~clk_k;

    int            checks = 0;
    int            errors = 0;
    int            cyc    = 0;
    string         tag    = "R10";
    logic [DW-1:0] ref_mem [2*NADDR];
    bit            exp_v [MAXCYC];
    logic [DW-1:0] exp0  [MAXCYC];
    logic [DW-1:0] exp1  [MAXCYC];

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                           input logic [DW-1:0] new_w,
                                           input logic [NL-1:0] mask_n);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < NL; l++)
            if (!mask_n[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom, $urandom});
    endfunction

    task automatic check(input string t, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", t, act, expv, $time);
        end
    endtask

    task automatic check_slot(input int k, input bit second);
        string t = tag;
        if (k >= 0 && exp_v[k]) begin
            check(t, DW'(rvalid), DW'(1));
            check(t, rdata, second ? exp1[k] : exp0[k]);
        end else begin
            check("R8", DW'(rvalid), DW'(0));
            check("R8", rdata, '0);
        end
        check("R9", DW'({echo_p, echo_n}), second ? DW'(2'b10) : DW'(2'b01));
    endtask

    // One cycle of stimulus; entered 2 units after a falling edge.
    task automatic step(input bit rdn, input bit wrn, input logic [AW-1:0] ra,
                        input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                        input logic [DW-1:0] d1, input logic [NL-1:0] b0,
                        input logic [NL-1:0] b1);
        int cur = cyc;
        rd_n = rdn; wr_n = wrn; rd_addr = ra; wdata = d0; bw_n = b0;
        @(posedge clk_k); #2;
        check_slot(cur - 2, 1'b1);
        wr_addr = wa; wdata = d1; bw_n = b1;
        if (!wrn && !rst) begin
            ref_mem[{wa, 1'b0}] = merge(ref_mem[{wa, 1'b0}], d0, b0);
            ref_mem[{wa, 1'b1}] = merge(ref_mem[{wa, 1'b1}], d1, b1);
        end
        exp_v[cur] = !rdn && !rst;
        exp0[cur]  = ref_mem[{ra, 1'b0}];
        exp1[cur]  = ref_mem[{ra, 1'b1}];
        @(negedge clk_k); #2;
        check_slot(cur - 1, 1'b0);
        cyc++;
    endtask

    task automatic idle();
        step(1'b1, 1'b1, '0, '0, '0, '0, '1, '1);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < MAXCYC; i++) exp_v[i] = 1'b0;
        @(negedge clk_k); #2;
        // R10: outputs quiet while held in reset
        tag = "R10";
        for (int i = 0; i < 4; i++) idle();
        rst = 1'b0;

        // R3: fill every pair, beat two carried on the falling edge
        tag = "R3";
        for (int a = 0; a < NADDR; a++)
            step(1'b1, 1'b0, '0, AW'(a), rnd_word(), rnd_word(), '0, '0);
        idle();

        // R1: single read, both words of the pair
        tag = "R1";
        step(1'b0, 1'b1, 6'd5, '0, '0, '0, '1, '1);
        idle(); idle();

        // R4: back-to-back reads form one stream
        tag = "R4";
        for (int a = 1; a <= 3; a++) step(1'b0, 1'b1, AW'(a), '0, '0, '0, '1, '1);
        idle(); idle();

        // R5: lane masks differ per beat
        tag = "R5";
        step(1'b1, 1'b0, '0, 6'd7, rnd_word(), rnd_word(), 4'b1010, 4'b0101);
        step(1'b0, 1'b1, 6'd7, '0, '0, '0, '1, '1);
        step(1'b1, 1'b0, '0, 6'd8, rnd_word(), rnd_word(), 4'b1111, 4'b1111);
        step(1'b0, 1'b1, 6'd8, '0, '0, '0, '1, '1);
        idle(); idle();

        // R7: same-edge read and partial write, then write after read
        tag = "R7";
        step(1'b0, 1'b0, 6'd9, 6'd9, rnd_word(), rnd_word(), 4'b0110, 4'b1001);
        step(1'b0, 1'b1, 6'd10, '0, '0, '0, '1, '1);
        step(1'b1, 1'b0, '0, 6'd10, rnd_word(), rnd_word(), '0, '0);
        step(1'b0, 1'b1, 6'd10, '0, '0, '0, '1, '1);
        idle(); idle();

        // R6: disabled write with live data, disabled read with live address
        tag = "R6";
        step(1'b1, 1'b1, 6'd11, 6'd11, rnd_word(), rnd_word(), '0, '0);
        step(1'b0, 1'b1, 6'd11, '0, '0, '0, '1, '1);
        idle(); idle();

        // R10: reset drops a read already in flight
        tag = "R10";
        step(1'b0, 1'b1, 6'd12, '0, '0, '0, '1, '1);
        exp_v[cyc - 1] = 1'b0;
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        idle(); idle();

        // R2: mixed random traffic
        tag = "R2";
        for (int i = 0; i < 300; i++)
            step(($urandom % 10) < 3, ($urandom % 10) < 4, AW'($urandom), AW'($urandom),
                 rnd_word(), rnd_word(), NL'($urandom), NL'($urandom));
        idle(); idle(); idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule